// File: doc/BRIEF.md
# ADC Readout Handshake Controller

This block sits on the host side of a parallel link to an integrating converter module. It fetches one conversion record per request. A start pulse drives the active-low request line. The controller then waits, for a variable time, until the module finishes its current integration and raises its acknowledge status line. Next it keeps the active-low output enable asserted while the module puts eight bytes on the 8-bit bus, each one flagged by the byte-valid status line. When acknowledge drops, the bytes are packed into a 64-bit record and a one-cycle done flag is raised. The record holds data gathered since the previous request, not a fresh conversion.

Both status lines are asynchronous to the host clock and pass through flop synchronizers. A byte is taken only on a rising edge of the synchronized valid line. A programmable cycle limit guards both phases of the handshake. A separate zero command drives the module's active-low auto-zero/reset line for a fixed number of cycles. The controller then stays busy while the module reports itself unavailable on the acknowledge line.

Top module: `adc_readout_ctrl`

## Requirements
- R1: During and after reset, dataReqN, outEnN and zeroN are 1, busy, recordDone, errTimeout and errShort are 0, and record is all zero.
- R2: A start pulse in the idle state, while synchronized acknowledge is 0, drives dataReqN to 0 on the next clock. dataReqN stays 0 until the synchronized acknowledge is seen at 1 and then returns to 1.
- R3: outEnN is 0 from the request through the end of the byte burst, and 1 whenever the controller is idle.
- R4: After eight bytes, acknowledge returning to 0 gives a one-cycle recordDone with the new record on the same cycle. Byte k received (k = 0 first) occupies record bits [8k+7:8k]. The record holds its value until the next recordDone.
- R5: Exactly one byte is taken per rising edge of the valid line, however long the line stays high. Valid pulses after the eighth byte of a burst are ignored.
- R6: If acknowledge does not rise within timeoutLimit cycles of the request, or does not fall within timeoutLimit cycles of its rise, errTimeout pulses for one cycle. The controller then returns to idle with dataReqN and outEnN at 1, and record is unchanged.
- R7: If acknowledge falls before eight bytes have arrived, errShort pulses for one cycle, recordDone stays 0 and record is unchanged.
- R8: A start pulse while synchronized acknowledge is 1 is ignored: dataReqN stays 1 and busy stays 0.
- R9: A zero pulse in the idle state drives zeroN to 0 for ZERO_CYC cycles. busy then stays 1 until synchronized acknowledge is 0 again.
- R10: A start pulse during the zero sequence is ignored and is not remembered afterwards.
- R11: At most one of recordDone, errTimeout and errShort is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle command to fetch a record |
| zeroReq | input | 1 | One-cycle command to auto-zero/reset the module |
| timeoutLimit | input | TMR_W | Cycle limit for each handshake phase |
| busData | input | 8 | Byte bus from the module |
| statAck | input | 1 | Module acknowledge/busy status (asynchronous) |
| statValid | input | 1 | Module byte-valid status (asynchronous) |
| dataReqN | output | 1 | Active-low data request to the module |
| outEnN | output | 1 | Active-low output enable to the module |
| zeroN | output | 1 | Active-low auto-zero/reset to the module |
| busy | output | 1 | Controller is not idle |
| record | output | 64 | Last completed record, first byte in bits [7:0] |
| recordDone | output | 1 | One-cycle flag: record updated |
| errTimeout | output | 1 | One-cycle flag: handshake phase overran its limit |
| errShort | output | 1 | One-cycle flag: burst ended with fewer than eight bytes |

## Verification
The bench holds the valid line high for twenty cycles. A design that samples levels instead of edges would then fill the record with repeats of one byte. It sends ten valid pulses in one burst, which catches a counter that wraps and overwrites the first bytes. It ends a burst after five bytes and checks for errShort with the old record still in place, so a design that publishes partial data fails. It also raises a start while acknowledge is high and while a zero sequence runs. A controller that queues or accepts those commands would pull dataReqN low where it must stay high.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_ACK, ST_BURST, ST_ZERO_HOLD, ST_ZERO_WAIT
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBurst;  // restart byte slot counter
    logic capture;   // store bus byte into current slot
    logic publish;   // copy assembled bytes to record
    logic tmrClr;    // restart phase timer
  } rdStrobe_t;
endpackage

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int BYTES       = 8,
  parameter int BYTE_W      = 8,
  parameter int TMR_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rdStrobe_t               strb,
  input  logic [BYTE_W-1:0]       busData,
  input  logic                    statAck,
  input  logic                    statValid,
  input  logic [TMR_W-1:0]        timeoutLimit,
  output logic                    ackS,
  output logic                    validRise,
  output logic                    fullBurst,
  output logic                    timerHit,
  output logic [BYTES*BYTE_W-1:0] record
);
  localparam int REC_W = BYTES * BYTE_W;
  localparam int CNT_W = $clog2(BYTES + 1);

  logic [SYNC_STAGES-1:0] ackSync, validSync;
  logic                   validPrev;
  logic [CNT_W-1:0]       byteCnt;
  logic [REC_W-1:0]       shadow;
  logic [TMR_W-1:0]       tmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSync   <= '0;
      validSync <= '0;
      validPrev <= 1'b0;
    end else begin
      ackSync   <= {ackSync[SYNC_STAGES-2:0], statAck};
      validSync <= {validSync[SYNC_STAGES-2:0], statValid};
      validPrev <= validSync[SYNC_STAGES-1];
    end
  end

  assign ackS      = ackSync[SYNC_STAGES-1];
  assign validRise = validSync[SYNC_STAGES-1] & ~validPrev;
  assign fullBurst = (byteCnt == CNT_W'(BYTES));
  assign timerHit  = (tmr >= timeoutLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          byteCnt <= '0;
    else if (strb.clrBurst)             byteCnt <= '0;
    else if (strb.capture && !fullBurst) byteCnt <= byteCnt + 1'b1;
  end

  // one register slot per byte, written when the counter points at it
  for (genvar g = 0; g < BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        shadow[g*BYTE_W +: BYTE_W] <= '0;
      else if (strb.capture && byteCnt == CNT_W'(g))
        shadow[g*BYTE_W +: BYTE_W] <= busData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             record <= '0;
    else if (strb.publish) record <= shadow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tmr <= '0;
    else if (strb.tmrClr) tmr <= '0;
    else if (!timerHit)   tmr <= tmr + 1'b1;
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_W'(BYTES));
  p_capture_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);
  p_publish_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.publish |-> fullBurst);
  p_record_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> $stable(record));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int ZERO_CYC = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      zeroReq,
  input  logic      ackS,
  input  logic      validRise,
  input  logic      fullBurst,
  input  logic      timerHit,
  output rdStrobe_t strb,
  output logic      dataReqN,
  output logic      outEnN,
  output logic      zeroN,
  output logic      busy,
  output logic      recordDone,
  output logic      errTimeout,
  output logic      errShort
);
  localparam int ZC_W = $clog2(ZERO_CYC + 1);

  rdState_t        state, stateNext;
  logic [ZC_W-1:0] zeroCnt;
  logic            toNext, shortNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    toNext    = 1'b0;
    shortNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strb.tmrClr   = 1'b1;
        strb.clrBurst = 1'b1;
        if (zeroReq)               stateNext = ST_ZERO_HOLD;
        else if (startReq && !ackS) stateNext = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        if (ackS) begin
          stateNext   = ST_BURST;
          strb.tmrClr = 1'b1;
        end else if (timerHit) begin
          stateNext = ST_IDLE;
          toNext    = 1'b1;
        end
      end
      ST_BURST: begin
        strb.capture = validRise && !fullBurst;
        if (!ackS) begin
          stateNext    = ST_IDLE;
          strb.publish = fullBurst;
          shortNext    = !fullBurst;
        end else if (timerHit) begin
          stateNext = ST_IDLE;
          toNext    = 1'b1;
        end
      end
      ST_ZERO_HOLD: if (zeroCnt == ZC_W'(ZERO_CYC - 1)) stateNext = ST_ZERO_WAIT;
      ST_ZERO_WAIT: if (!ackS) stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      zeroCnt    <= '0;
      recordDone <= 1'b0;
      errTimeout <= 1'b0;
      errShort   <= 1'b0;
    end else begin
      state      <= stateNext;
      zeroCnt    <= (state == ST_ZERO_HOLD) ? zeroCnt + 1'b1 : '0;
      recordDone <= strb.publish;
      errTimeout <= toNext;
      errShort   <= shortNext;
    end
  end

  assign dataReqN = (state != ST_WAIT_ACK);
  assign outEnN   = !(state == ST_WAIT_ACK || state == ST_BURST);
  assign zeroN    = (state != ST_ZERO_HOLD);
  assign busy     = (state != ST_IDLE);

  p_req_needs_idle_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReqN) |-> $past(!ackS));
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({recordDone, errTimeout, errShort}));
  p_done_after_ack_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    recordDone |-> $past(!ackS));
  p_oe_covers_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dataReqN |-> !outEnN);
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int BYTES       = 8,
  parameter int BYTE_W      = 8,
  parameter int TMR_W       = 24,
  parameter int ZERO_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startReq,
  input  logic                    zeroReq,
  input  logic [TMR_W-1:0]        timeoutLimit,
  input  logic [BYTE_W-1:0]       busData,
  input  logic                    statAck,
  input  logic                    statValid,
  output logic                    dataReqN,
  output logic                    outEnN,
  output logic                    zeroN,
  output logic                    busy,
  output logic [BYTES*BYTE_W-1:0] record,
  output logic                    recordDone,
  output logic                    errTimeout,
  output logic                    errShort
);
  rdStrobe_t strb;
  logic      ackS, validRise, fullBurst, timerHit;

  adc_rd_ctrl #(.ZERO_CYC(ZERO_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .zeroReq(zeroReq),
    .ackS(ackS), .validRise(validRise), .fullBurst(fullBurst), .timerHit(timerHit),
    .strb(strb), .dataReqN(dataReqN), .outEnN(outEnN), .zeroN(zeroN), .busy(busy),
    .recordDone(recordDone), .errTimeout(errTimeout), .errShort(errShort)
  );

  adc_rd_datapath #(
    .BYTES(BYTES), .BYTE_W(BYTE_W), .TMR_W(TMR_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busData(busData),
    .statAck(statAck), .statValid(statValid), .timeoutLimit(timeoutLimit),
    .ackS(ackS), .validRise(validRise), .fullBurst(fullBurst), .timerHit(timerHit),
    .record(record)
  );
endmodule

// File: tb/test_adc_readout_ctrl.sv
`timescale 1ns/1ps
module test_adc_readout_ctrl;
  localparam int TLIM = 300;
  localparam int ZCYC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, zeroReq = 1'b0;
  logic [23:0] timeoutLimit = 24'(TLIM);
  logic [7:0]  busData = '0;
  logic        statAck = 1'b0, statValid = 1'b0;
  logic        dataReqN, outEnN, zeroN, busy, recordDone, errTimeout, errShort;
  logic [63:0] record;

  typedef struct { int kind; logic [63:0] rec; } ev_t;  // kind: 0 done, 1 timeout, 2 short
  ev_t         expQ[$];
  logic [63:0] lastRec = '0;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_readout_ctrl #(.ZERO_CYC(ZCYC)) i_adc_readout_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .zeroReq(zeroReq),
    .timeoutLimit(timeoutLimit), .busData(busData), .statAck(statAck),
    .statValid(statValid), .dataReqN(dataReqN), .outEnN(outEnN), .zeroN(zeroN),
    .busy(busy), .record(record), .recordDone(recordDone),
    .errTimeout(errTimeout), .errShort(errShort)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byteVal(input int seed, input int i);
    return 8'((seed * 37 + i * 53) ^ (i << 4));
  endfunction

  // monitor: pop one expected event per flag cycle
  always @(negedge clk) begin
    if (rstN) begin
      chk($countones({recordDone, errTimeout, errShort}) <= 1, "R11 flags exclusive",
          64'({recordDone, errTimeout, errShort}), 64'd0);
      if (recordDone || errTimeout || errShort) begin
        int k;
        k = recordDone ? 0 : (errTimeout ? 1 : 2);
        if (expQ.size() == 0) chk(1'b0, "R4/R6/R7 unexpected event", 64'(k), 64'hFFFF);
        else begin
          ev_t e;
          e = expQ.pop_front();
          chk(k == e.kind, "R4/R6/R7 event kind", 64'(k), 64'(e.kind));
          chk(record == e.rec, k == 0 ? "R4 record" : (k == 1 ? "R6 record kept" : "R7 record kept"),
              record, e.rec);
        end
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  // request plus module model: n valid pulses; ack dropped at end if dropAck
  task automatic transfer(input int seed, input int n, input int ackDelay, input int hold, input bit dropAck);
    ev_t e;
    e.rec = '0;
    for (int i = 0; i < 8 && i < n; i++) e.rec[8*i +: 8] = byteVal(seed, i);
    if (!dropAck)   begin e.kind = 1; e.rec = lastRec; end
    else if (n < 8) begin e.kind = 2; e.rec = lastRec; end
    else            begin e.kind = 0; lastRec = e.rec; end
    expQ.push_back(e);
    pulseStart();
    chk(dataReqN == 1'b0, "R2 request asserted", 64'(dataReqN), 64'd0);
    repeat (ackDelay) @(negedge clk);
    chk(dataReqN == 1'b0, "R2 request held until ack", 64'(dataReqN), 64'd0);
    statAck = 1'b1;
    repeat (5) @(negedge clk);
    chk(dataReqN == 1'b1, "R2 request released", 64'(dataReqN), 64'd1);
    chk(outEnN == 1'b0, "R3 enable during burst", 64'(outEnN), 64'd0);
    for (int i = 0; i < n; i++) begin
      busData = byteVal(seed, i);
      repeat (2) @(negedge clk);
      statValid = 1'b1;
      repeat (hold) @(negedge clk);
      statValid = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk(outEnN == 1'b0, "R3 enable until ack falls", 64'(outEnN), 64'd0);
    if (dropAck) begin
      statAck = 1'b0;
      repeat (10) @(negedge clk);
    end else begin
      repeat (TLIM + 10) @(negedge clk);
      chk(outEnN == 1'b1 && dataReqN == 1'b1, "R6 lines released", 64'({outEnN, dataReqN}), 64'd3);
      statAck = 1'b0;
      repeat (6) @(negedge clk);
    end
    chk(outEnN == 1'b1 && busy == 1'b0, "R3 idle after burst", 64'({outEnN, busy}), 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dataReqN && outEnN && zeroN && !busy && !recordDone && !errTimeout && !errShort,
        "R1 outputs in reset", 64'({dataReqN, outEnN, zeroN, busy}), 64'hE);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(record == '0 && !busy && outEnN, "R1 state after reset", record, 64'd0);

    transfer(1, 8, 10, 4, 1'b1);     // R4 basic record
    transfer(2, 8, 150, 20, 1'b1);   // R5 long valid high, long ack wait
    transfer(3, 10, 3, 4, 1'b1);     // R5 extra valid pulses ignored
    transfer(4, 5, 5, 4, 1'b1);      // R7 short burst
    transfer(5, 8, 5, 4, 1'b0);      // R6 ack never falls

    // R6: no acknowledge at all
    begin
      ev_t e;
      e.kind = 1; e.rec = lastRec;
      expQ.push_back(e);
      pulseStart();
      chk(dataReqN == 1'b0, "R6 request issued", 64'(dataReqN), 64'd0);
      repeat (TLIM + 10) @(negedge clk);
      chk(dataReqN == 1'b1 && outEnN == 1'b1 && !busy, "R6 returned idle",
          64'({dataReqN, outEnN, busy}), 64'd6);
    end

    // R8: start while module reports busy
    statAck = 1'b1;
    repeat (5) @(negedge clk);
    pulseStart();
    repeat (10) begin
      chk(dataReqN == 1'b1 && !busy, "R8 start ignored", 64'({dataReqN, busy}), 64'd2);
      @(negedge clk);
    end
    statAck = 1'b0;
    repeat (5) @(negedge clk);

    // R9/R10: zero sequence
    @(negedge clk) zeroReq = 1'b1;
    @(negedge clk) zeroReq = 1'b0;
    chk(zeroN == 1'b0 && busy, "R9 zero asserted", 64'({zeroN, busy}), 64'd1);
    statAck = 1'b1;
    repeat (ZCYC + 2) @(negedge clk);
    chk(zeroN == 1'b1 && busy, "R9 zero released, still busy", 64'({zeroN, busy}), 64'd3);
    pulseStart();
    repeat (5) @(negedge clk);
    chk(dataReqN == 1'b1, "R10 start ignored in zero", 64'(dataReqN), 64'd1);
    repeat (50) @(negedge clk);
    chk(busy == 1'b1, "R9 busy while ack high", 64'(busy), 64'd1);
    statAck = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy && dataReqN, "R10 start not remembered", 64'({busy, dataReqN}), 64'd1);

    transfer(6, 8, 20, 6, 1'b1);     // R4 record after zero
    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R4/R6/R7 all events seen", 64'(expQ.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule